// File: doc/BRIEF.md
# LCD Controller Power-Save Sequencer

This block decides which power-save state a display controller is in and applies that state to the controller's edges. It combines an active-low hardware suspend pin, an active-low doze pin, a software power-save request and a doze behaviour select into one resolved mode: normal, doze or suspend. In suspend it blocks the CPU bus inputs, forces the LCD panel data and timing outputs low (or releases them to high impedance), and switches the panel power enable off. When the panel comes back, the outputs stay forced until a programmed number of frames has passed.

The block also produces a reduced DRAM refresh, a CAS-before-RAS pulse pair made from the edges of a selected timing source. Outside suspend this source is an internal divider of the main clock. In suspend a select field can move it to the memory enable input or to a slow 32 kHz power-down clock. A change of source goes through a handshake: the old source stops, the pulse generator goes quiet, and only then does the new source take over. All inputs from outside the clock domain pass through two-stage synchronizers.

Top module: `lcd_pwrsave_seq`

## Requirements
- R1: mode_o uses 0 for normal, 1 for doze and 2 for suspend, and never shows 3. Priority: susp_n_i low gives 2; otherwise sw_mode_i equal to 2 gives 2; otherwise doze_n_i low or sw_mode_i equal to 1 gives 1; otherwise 0. A sw_mode_i of 0 or 3 requests nothing.
- R2: While susp_n_i is low, doze_n_i has no effect on mode_o.
- R3: While susp_n_i holds the block in suspend, cpu_valid_o, cpu_addr_o and cpu_data_o are all zero. At every other time they copy their inputs, and this includes a suspend that software requested.
- R4: In mode 2, lcd_pwr_n_o is 1 and every panel output (pnl_ud_o, pnl_ld_o, pnl_shclk_o, pnl_line_o, pnl_frame_o, pnl_acm_o) is 0. Whenever the panel outputs are forced, pnl_oe_o is the inverse of hiz_sel_i. When they are not forced, pnl_oe_o is 1.
- R5: In doze, bit 0 of doze_sel_i forces the panel outputs low. Bit 1 drives lcd_pwr_n_o high and also forces the panel outputs. The value 00 leaves panel power on and the panel outputs copying their inputs.
- R6: A change on susp_n_i or doze_n_i reaches mode_o at the third rising clk edge after the change. A change on sw_mode_i or doze_sel_i takes effect at the first rising edge.
- R7: When lcd_pwr_n_o returns to 0, the panel outputs stay forced until pwr_dly_i frame_i pulses have been counted, starting from that edge. The force is released at the next edge after the count reaches pwr_dly_i. With pwr_dly_i equal to 0, the force is released at the same edge on which power returns.
- R8: The refresh is generated once per period of the selected source. A rising edge of the source drives cas_n_o low at the third clk edge after it. A falling edge of the source then drives ras_n_o low at its third edge. The next rising edge returns both outputs high at its third edge, and cas_n_o falls again one edge later. ras_n_o is never low while cas_n_o is high.
- R9: Outside suspend, the refresh source is an internal divider with a period of REF_DIV clk cycles. In suspend, refsel_i selects the source: 0 is the divider, 1 is memen_i, 2 is pdclk_i and 3 is the divider. On any change of source, ras_n_o and cas_n_o stay high for at least the two edges that follow the old source's last edge. The new source's present level is not taken as an edge.
- R10: After reset, mode_o is 0, lcd_pwr_n_o is 0, ras_n_o and cas_n_o are 1, pnl_oe_o is 1, and the CPU and panel outputs copy their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| susp_n_i | input | 1 | Hardware suspend request, active low, asynchronous |
| doze_n_i | input | 1 | Doze request, active low, asynchronous |
| sw_mode_i | input | 2 | Software power-save request (0 none, 1 doze, 2 suspend) |
| doze_sel_i | input | 2 | Doze behaviour: bit 0 forces the panel outputs, bit 1 turns panel power off |
| hiz_sel_i | input | 1 | Forced panel outputs go to high impedance instead of low |
| refsel_i | input | 2 | Refresh source used in suspend |
| pwr_dly_i | input | DLYW | Frames to keep the outputs forced after power returns |
| frame_i | input | 1 | One-cycle pulse per frame period |
| memen_i | input | 1 | Memory enable input used as a refresh source |
| pdclk_i | input | 1 | 32 kHz power-down clock, asynchronous |
| cpu_valid_i | input | 1 | CPU bus access valid |
| cpu_addr_i | input | AW | CPU address |
| cpu_data_i | input | DW | CPU write data |
| pnl_ud_i | input | 4 | Upper panel data nibble from the display pipeline |
| pnl_ld_i | input | 4 | Lower panel data nibble from the display pipeline |
| pnl_shclk_i | input | 1 | Panel shift clock from the display pipeline |
| pnl_line_i | input | 1 | Line pulse from the display pipeline |
| pnl_frame_i | input | 1 | Frame start from the display pipeline |
| pnl_acm_i | input | 1 | AC modulation from the display pipeline |
| mode_o | output | 2 | Resolved mode (0 normal, 1 doze, 2 suspend) |
| cpu_valid_o | output | 1 | Gated CPU valid |
| cpu_addr_o | output | AW | Gated CPU address |
| cpu_data_o | output | DW | Gated CPU data |
| pnl_ud_o | output | 4 | Upper panel data nibble |
| pnl_ld_o | output | 4 | Lower panel data nibble |
| pnl_shclk_o | output | 1 | Panel shift clock |
| pnl_line_o | output | 1 | Panel line pulse |
| pnl_frame_o | output | 1 | Panel frame start |
| pnl_acm_o | output | 1 | Panel AC modulation |
| pnl_oe_o | output | 1 | Panel output drive enable (0 means high impedance) |
| lcd_pwr_n_o | output | 1 | Panel power enable, active low |
| ras_n_o | output | 1 | Refresh RAS, active low |
| cas_n_o | output | 1 | Refresh CAS, active low |

## Verification
The mode resolution is tried with the doze pin alone, with each software request alone, and with the suspend pin asserted together with the doze pin and then with a software doze request. These cases separate the priority order from a plain OR of the requests, and a software suspend shows that only the pin masks the CPU bus. Each doze select value is applied while dozing, which shows whether forcing the panel outputs and cutting panel power act independently. A hand-driven power-down clock checks where each RAS/CAS edge falls after the source switch and after the quiet gap. Power-up with a frame delay of zero and of three shows whether the release counts frames from the correct edge.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_DOZE = 2'd1,
        MODE_SUSP = 2'd2
    } pwr_mode_e;

    typedef enum logic [1:0] {
        SRC_MAIN  = 2'd0,
        SRC_MEMEN = 2'd1,
        SRC_PD    = 2'd2
    } ref_src_e;

    typedef enum logic [1:0] {
        SW_RUN   = 2'd0,
        SW_DRAIN = 2'd1,
        SW_LOAD  = 2'd2
    } sw_state_e;

    typedef enum logic [1:0] {
        G_IDLE = 2'd0,
        G_CAS  = 2'd1,
        G_RAS  = 2'd2,
        G_REL  = 2'd3
    } gen_state_e;

    localparam logic [1:0] REQ_DOZE = 2'd1;
    localparam logic [1:0] REQ_SUSP = 2'd2;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/lps_mode_ctrl.sv
module lps_mode_ctrl
    import lps_pkg::*;
#(
    parameter int DLYW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            susp_n_s,
    input  logic            doze_n_s,
    input  logic [1:0]      sw_mode_i,
    input  logic [1:0]      doze_sel_i,
    input  logic            frame_i,
    input  logic [DLYW-1:0] pwr_dly_i,
    output pwr_mode_e       mode_o,
    output logic            hw_susp_o,
    output logic            pwr_off_o,
    output logic            clamp_o
);

    typedef struct packed {
        pwr_mode_e       mode;
        logic            hw_susp;
        logic            pwr_off;
        logic            blank;
        logic            hold;
        logic [DLYW-1:0] cnt;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.hw_susp = !susp_n_s;

        if (!susp_n_s) begin
            st_d.mode = MODE_SUSP;
        end else if (sw_mode_i == REQ_SUSP) begin
            st_d.mode = MODE_SUSP;
        end else if (!doze_n_s || sw_mode_i == REQ_DOZE) begin
            st_d.mode = MODE_DOZE;
        end else begin
            st_d.mode = MODE_NORM;
        end

        st_d.pwr_off = (st_d.mode == MODE_SUSP) ||
                       (st_d.mode == MODE_DOZE && doze_sel_i[1]);
        st_d.blank   = (st_d.mode == MODE_DOZE) && doze_sel_i[0];

        if (st_d.pwr_off) begin
            st_d.hold = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.hold) begin
            if (st_q.cnt >= pwr_dly_i) begin
                st_d.hold = 1'b0;
            end else if (frame_i) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_NORM, hw_susp: 1'b0, pwr_off: 1'b0,
                      blank: 1'b0, hold: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign hw_susp_o = st_q.hw_susp;
    assign pwr_off_o = st_q.pwr_off;
    assign clamp_o   = st_q.pwr_off | st_q.hold | st_q.blank;

endmodule

// File: rtl/lps_refresh.sv
module lps_refresh
    import lps_pkg::*;
#(
    parameter int REF_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_susp_i,
    input  logic [1:0] refsel_i,
    input  logic       memen_s,
    input  logic       pdclk_s,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic [1:0] src_o
);

    localparam int DIVW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
    localparam int HALF = REF_DIV / 2;

    typedef struct packed {
        sw_state_e       sw;
        ref_src_e        src;
        gen_state_e      gen;
        logic            prev;
        logic            ras_n;
        logic            cas_n;
        logic [DIVW-1:0] div;
    } ref_st_t;

    ref_st_t  st_d, st_q;
    ref_src_e eff_src;
    logic     phase, lvl, rise, fall;

    always_comb begin
        if (!in_susp_i) begin
            eff_src = SRC_MAIN;
        end else begin
            case (refsel_i)
                2'd1:    eff_src = SRC_MEMEN;
                2'd2:    eff_src = SRC_PD;
                default: eff_src = SRC_MAIN;
            endcase
        end
    end

    assign phase = (st_q.div >= DIVW'(HALF));

    always_comb begin
        case (st_q.src)
            SRC_MEMEN: lvl = memen_s;
            SRC_PD:    lvl = pdclk_s;
            default:   lvl = phase;
        endcase
    end

    assign rise = lvl & ~st_q.prev;
    assign fall = ~lvl & st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        st_d.div  = (st_q.div == DIVW'(REF_DIV - 1)) ? '0 : st_q.div + 1'b1;

        case (st_q.sw)
            SW_RUN: begin
                if (eff_src != st_q.src) st_d.sw = SW_DRAIN;
            end
            SW_DRAIN: begin
                st_d.sw  = SW_LOAD;
                st_d.src = eff_src;
            end
            default: st_d.sw = SW_RUN;
        endcase

        if (st_q.sw != SW_RUN) begin
            st_d.gen = G_IDLE;
        end else begin
            case (st_q.gen)
                G_IDLE: if (rise) st_d.gen = G_CAS;
                G_CAS:  if (fall) st_d.gen = G_RAS;
                G_RAS:  if (rise) st_d.gen = G_REL;
                default: st_d.gen = G_CAS;
            endcase
        end

        st_d.cas_n = !(st_d.gen == G_CAS || st_d.gen == G_RAS);
        st_d.ras_n = !(st_d.gen == G_RAS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sw: SW_RUN, src: SRC_MAIN, gen: G_IDLE, prev: 1'b0,
                      ras_n: 1'b1, cas_n: 1'b1, div: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ras_n_o = st_q.ras_n;
    assign cas_n_o = st_q.cas_n;
    assign src_o   = st_q.src;

endmodule

// File: rtl/lcd_pwrsave_seq.sv
module lcd_pwrsave_seq
    import lps_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int DLYW    = 4,
    parameter int REF_DIV = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            susp_n_i,
    input  logic            doze_n_i,
    input  logic [1:0]      sw_mode_i,
    input  logic [1:0]      doze_sel_i,
    input  logic            hiz_sel_i,
    input  logic [1:0]      refsel_i,
    input  logic [DLYW-1:0] pwr_dly_i,
    input  logic            frame_i,
    input  logic            memen_i,
    input  logic            pdclk_i,
    input  logic            cpu_valid_i,
    input  logic [AW-1:0]   cpu_addr_i,
    input  logic [DW-1:0]   cpu_data_i,
    input  logic [3:0]      pnl_ud_i,
    input  logic [3:0]      pnl_ld_i,
    input  logic            pnl_shclk_i,
    input  logic            pnl_line_i,
    input  logic            pnl_frame_i,
    input  logic            pnl_acm_i,
    output logic [1:0]      mode_o,
    output logic            cpu_valid_o,
    output logic [AW-1:0]   cpu_addr_o,
    output logic [DW-1:0]   cpu_data_o,
    output logic [3:0]      pnl_ud_o,
    output logic [3:0]      pnl_ld_o,
    output logic            pnl_shclk_o,
    output logic            pnl_line_o,
    output logic            pnl_frame_o,
    output logic            pnl_acm_o,
    output logic            pnl_oe_o,
    output logic            lcd_pwr_n_o,
    output logic            ras_n_o,
    output logic            cas_n_o
);

    localparam int             NSYNC    = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b1100;

    logic [NSYNC-1:0] async_in, sync_out;
    pwr_mode_e        mode;
    logic             hw_susp, pwr_off, clamp;
    logic [1:0]       ref_src;

    assign async_in = {susp_n_i, doze_n_i, memen_i, pdclk_i};

    lps_sync #(.W(NSYNC), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (async_in),
        .dout  (sync_out)
    );

    lps_mode_ctrl #(.DLYW(DLYW)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .susp_n_s   (sync_out[3]),
        .doze_n_s   (sync_out[2]),
        .sw_mode_i  (sw_mode_i),
        .doze_sel_i (doze_sel_i),
        .frame_i    (frame_i),
        .pwr_dly_i  (pwr_dly_i),
        .mode_o     (mode),
        .hw_susp_o  (hw_susp),
        .pwr_off_o  (pwr_off),
        .clamp_o    (clamp)
    );

    lps_refresh #(.REF_DIV(REF_DIV)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_susp_i (mode == MODE_SUSP),
        .refsel_i  (refsel_i),
        .memen_s   (sync_out[1]),
        .pdclk_s   (sync_out[0]),
        .ras_n_o   (ras_n_o),
        .cas_n_o   (cas_n_o),
        .src_o     (ref_src)
    );

    assign mode_o      = mode;
    assign lcd_pwr_n_o = pwr_off;

    assign cpu_valid_o = cpu_valid_i & ~hw_susp;
    assign cpu_addr_o  = hw_susp ? '0 : cpu_addr_i;
    assign cpu_data_o  = hw_susp ? '0 : cpu_data_i;

    assign pnl_ud_o    = clamp ? 4'h0 : pnl_ud_i;
    assign pnl_ld_o    = clamp ? 4'h0 : pnl_ld_i;
    assign pnl_shclk_o = pnl_shclk_i & ~clamp;
    assign pnl_line_o  = pnl_line_i  & ~clamp;
    assign pnl_frame_o = pnl_frame_i & ~clamp;
    assign pnl_acm_o   = pnl_acm_i   & ~clamp;
    assign pnl_oe_o    = ~(clamp & hiz_sel_i);

endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_susp,
    input logic [1:0]    mode_o,
    input logic          lcd_pwr_n_o,
    input logic          cpu_valid_o,
    input logic [AW-1:0] cpu_addr_o,
    input logic [DW-1:0] cpu_data_o,
    input logic [3:0]    pnl_ud_o,
    input logic [3:0]    pnl_ld_o,
    input logic [3:0]    pnl_ctl,
    input logic          ras_n_o,
    input logic          cas_n_o,
    input logic [1:0]    ref_src
);

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);  // R1

    AST_HW_SUSP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        hw_susp |-> (!cpu_valid_o && cpu_addr_o == '0 && cpu_data_o == '0));  // R3

    AST_SUSP_PANEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (lcd_pwr_n_o && pnl_ud_o == 4'h0 &&
                              pnl_ld_o == 4'h0 && pnl_ctl == 4'h0));  // R4

    AST_PWR_OFF_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_pwr_n_o |-> (pnl_ud_o == 4'h0 && pnl_ld_o == 4'h0 && pnl_ctl == 4'h0));  // R5

    AST_RAS_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> !cas_n_o);  // R8

    AST_RAS_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> $past(!cas_n_o));  // R8

    AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_src) |-> (ras_n_o && cas_n_o));  // R9

endmodule

bind lcd_pwrsave_seq lps_checker #(.AW(AW), .DW(DW)) u_lps_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_susp     (hw_susp),
    .mode_o      (mode_o),
    .lcd_pwr_n_o (lcd_pwr_n_o),
    .cpu_valid_o (cpu_valid_o),
    .cpu_addr_o  (cpu_addr_o),
    .cpu_data_o  (cpu_data_o),
    .pnl_ud_o    (pnl_ud_o),
    .pnl_ld_o    (pnl_ld_o),
    .pnl_ctl     ({pnl_shclk_o, pnl_line_o, pnl_frame_o, pnl_acm_o}),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .ref_src     (ref_src)
);

// File: tb/test_lcd_pwrsave_seq.sv
module test_lcd_pwrsave_seq;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int DLYW = 4;

    localparam int F_MODE = 0, F_PWRN = 1, F_UD = 2, F_LD = 3, F_CTL = 4, F_OE = 5,
                   F_CVAL = 6, F_CADDR = 7, F_CDATA = 8, F_RAS = 9, F_CAS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic susp_n_i = 1'b1, doze_n_i = 1'b1, hiz_sel_i = 1'b0, frame_i = 1'b0;
    logic memen_i = 1'b0, pdclk_i = 1'b0, cpu_valid_i = 1'b1;
    logic [1:0] sw_mode_i = 2'd0, doze_sel_i = 2'd0, refsel_i = 2'd2;
    logic [DLYW-1:0] pwr_dly_i = '0;
    logic [AW-1:0] cpu_addr_i = 16'hA5C3;
    logic [DW-1:0] cpu_data_i = 8'h5A;
    logic [3:0] pnl_ud_i = 4'h9, pnl_ld_i = 4'h6;
    logic pnl_shclk_i = 1'b1, pnl_line_i = 1'b0, pnl_frame_i = 1'b1, pnl_acm_i = 1'b1;
    logic [1:0] mode_o;
    logic cpu_valid_o, pnl_shclk_o, pnl_line_o, pnl_frame_o, pnl_acm_o, pnl_oe_o;
    logic lcd_pwr_n_o, ras_n_o, cas_n_o;
    logic [AW-1:0] cpu_addr_o;
    logic [DW-1:0] cpu_data_o;
    logic [3:0] pnl_ud_o, pnl_ld_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        int    fld;
        int    exp;
    } item_t;

    item_t sbq[$];

    always #5 clk = ~clk;

    lcd_pwrsave_seq i_lcd_pwrsave_seq (
        .clk(clk), .rst_n(rst_n), .susp_n_i(susp_n_i), .doze_n_i(doze_n_i),
        .sw_mode_i(sw_mode_i), .doze_sel_i(doze_sel_i), .hiz_sel_i(hiz_sel_i),
        .refsel_i(refsel_i), .pwr_dly_i(pwr_dly_i), .frame_i(frame_i),
        .memen_i(memen_i), .pdclk_i(pdclk_i), .cpu_valid_i(cpu_valid_i),
        .cpu_addr_i(cpu_addr_i), .cpu_data_i(cpu_data_i), .pnl_ud_i(pnl_ud_i),
        .pnl_ld_i(pnl_ld_i), .pnl_shclk_i(pnl_shclk_i), .pnl_line_i(pnl_line_i),
        .pnl_frame_i(pnl_frame_i), .pnl_acm_i(pnl_acm_i), .mode_o(mode_o),
        .cpu_valid_o(cpu_valid_o), .cpu_addr_o(cpu_addr_o), .cpu_data_o(cpu_data_o),
        .pnl_ud_o(pnl_ud_o), .pnl_ld_o(pnl_ld_o), .pnl_shclk_o(pnl_shclk_o),
        .pnl_line_o(pnl_line_o), .pnl_frame_o(pnl_frame_o), .pnl_acm_o(pnl_acm_o),
        .pnl_oe_o(pnl_oe_o), .lcd_pwr_n_o(lcd_pwr_n_o), .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o)
    );

    function automatic int sample(int fld);
        case (fld)
            F_MODE:  return int'(mode_o);
            F_PWRN:  return int'(lcd_pwr_n_o);
            F_UD:    return int'(pnl_ud_o);
            F_LD:    return int'(pnl_ld_o);
            F_CTL:   return int'({pnl_shclk_o, pnl_line_o, pnl_frame_o, pnl_acm_o});
            F_OE:    return int'(pnl_oe_o);
            F_CVAL:  return int'(cpu_valid_o);
            F_CADDR: return int'(cpu_addr_o);
            F_CDATA: return int'(cpu_data_o);
            F_RAS:   return int'(ras_n_o);
            default: return int'(cas_n_o);
        endcase
    endfunction

    // driver side: push an expectation for the current cycle
    task automatic expect_now(string req, int fld, int exp);
        sbq.push_back('{req: req, fld: fld, exp: exp});
    endtask

    task automatic direct_check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: compare all pending expectations away from the active edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            int act;
            it = sbq.pop_front();
            act = sample(it.fld);
            checks++;
            if (act != it.exp) begin
                fails++;
                $display("FAIL %s field=%0d actual=%0d expected=%0d", it.req, it.fld, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cas_seen, ras_seen, bad;
        ticks(3);
        rst_n = 1'b1;
        tick();
        // R10 reset state
        expect_now("R10", F_MODE, 0);
        expect_now("R10", F_PWRN, 0);
        expect_now("R10", F_RAS, 1);
        expect_now("R10", F_CAS, 1);
        expect_now("R10", F_OE, 1);
        expect_now("R10", F_UD, 9);
        expect_now("R10", F_CADDR, 16'hA5C3);

        // R9 divider refresh outside suspend
        cas_seen = 0; ras_seen = 0; bad = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (!cas_n_o) cas_seen++;
            if (!ras_n_o) ras_seen++;
            if (!ras_n_o && cas_n_o) bad++;
        end
        direct_check("R9", "divider cas low cycles", int'(cas_seen > 0), 1);
        direct_check("R9", "divider ras low cycles", int'(ras_seen > 0), 1);
        direct_check("R8", "ras low with cas high", bad, 0);

        // R6/R1 doze pin latency
        doze_n_i = 1'b0;
        ticks(2);
        expect_now("R6", F_MODE, 0);
        tick();
        expect_now("R6", F_MODE, 1);
        expect_now("R5", F_PWRN, 0);
        expect_now("R5", F_UD, 9);
        doze_sel_i = 2'b01;
        tick();
        expect_now("R5", F_UD, 0);
        expect_now("R5", F_CTL, 0);
        expect_now("R5", F_PWRN, 0);
        doze_sel_i = 2'b10;
        tick();
        expect_now("R5", F_PWRN, 1);
        expect_now("R5", F_LD, 0);
        doze_sel_i = 2'b00;
        tick();
        // R7 with zero delay: release on the power-return edge
        expect_now("R7", F_PWRN, 0);
        expect_now("R7", F_UD, 9);
        doze_n_i = 1'b1;
        ticks(3);
        expect_now("R1", F_MODE, 0);

        // software requests
        sw_mode_i = 2'd2;
        tick();
        expect_now("R6", F_MODE, 2);
        expect_now("R3", F_CVAL, 1);
        expect_now("R3", F_CADDR, 16'hA5C3);
        expect_now("R4", F_PWRN, 1);
        expect_now("R4", F_UD, 0);
        sw_mode_i = 2'd1;
        tick();
        expect_now("R1", F_MODE, 1);
        sw_mode_i = 2'd0;
        tick();
        expect_now("R1", F_MODE, 0);

        // hardware suspend together with doze
        pwr_dly_i = 4'd3;
        refsel_i = 2'd2;
        pdclk_i = 1'b0;
        susp_n_i = 1'b0;
        doze_n_i = 1'b0;
        ticks(2);
        expect_now("R2", F_MODE, 0);
        tick();
        expect_now("R2", F_MODE, 2);
        expect_now("R3", F_CVAL, 0);
        expect_now("R3", F_CADDR, 0);
        expect_now("R3", F_CDATA, 0);
        expect_now("R4", F_PWRN, 1);
        expect_now("R4", F_UD, 0);
        expect_now("R4", F_CTL, 0);
        expect_now("R4", F_OE, 1);
        ticks(2);
        expect_now("R9", F_RAS, 1);
        expect_now("R9", F_CAS, 1);
        tick();
        expect_now("R9", F_RAS, 1);
        expect_now("R9", F_CAS, 1);
        hiz_sel_i = 1'b1;
        #1;
        expect_now("R4", F_OE, 0);
        tick();
        hiz_sel_i = 1'b0;
        doze_n_i = 1'b1;
        ticks(3);
        expect_now("R2", F_MODE, 2);
        sw_mode_i = 2'd1;
        tick();
        expect_now("R1", F_MODE, 2);
        sw_mode_i = 2'd0;

        // R8 refresh from power-down clock
        ticks(4);
        pdclk_i = 1'b1;
        ticks(2);
        expect_now("R8", F_CAS, 1);
        tick();
        expect_now("R8", F_CAS, 0);
        expect_now("R8", F_RAS, 1);
        ticks(3);
        pdclk_i = 1'b0;
        ticks(2);
        expect_now("R8", F_RAS, 1);
        tick();
        expect_now("R8", F_RAS, 0);
        expect_now("R8", F_CAS, 0);
        ticks(3);
        pdclk_i = 1'b1;
        ticks(3);
        expect_now("R8", F_RAS, 1);
        expect_now("R8", F_CAS, 1);
        tick();
        expect_now("R8", F_CAS, 0);
        expect_now("R8", F_RAS, 1);
        ticks(2);
        pdclk_i = 1'b0;
        ticks(4);

        // R7 exit with a three-frame delay
        susp_n_i = 1'b1;
        ticks(3);
        expect_now("R7", F_MODE, 0);
        expect_now("R7", F_PWRN, 0);
        expect_now("R7", F_UD, 0);
        for (int k = 0; k < 2; k++) begin
            frame_i = 1'b1;
            tick();
            frame_i = 1'b0;
            tick();
        end
        expect_now("R7", F_UD, 0);
        frame_i = 1'b1;
        tick();
        frame_i = 1'b0;
        expect_now("R7", F_UD, 0);
        tick();
        expect_now("R7", F_UD, 9);
        expect_now("R7", F_CTL, 4'b1011);
        expect_now("R7", F_CVAL, 1);

        ticks(4);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule